// File: doc/BRIEF.md
# Multi-Context Instruction Stepping Engine

The engine runs a small fixed program over packets, keeping one packet in flight per hardware thread context. Each program step works like one very wide instruction. The engine sends at most one call to each of two functional units and then parks the context behind a reply barrier. Once every reply for that step has returned, the engine writes the results into the context's variables and takes a multiway jump to the next step. While one context waits, another context that is ready may issue, so unit latency is hidden by interleaving threads. Both units are shared by all contexts through one request port and one reply port each. Every request and reply carries the context number as a tag. Replies may arrive in any order and after any delay.

Every context holds a state, a step pointer, the packet word, two variables `a` and `b`, a per-unit pending mask and a per-unit reply buffer. The states are IDLE, READY and WAIT, with these transitions:
- IDLE→READY on load, when a packet is handed in.
- READY→WAIT on issue, when the round-robin arbiter grants the context.
- WAIT→READY on release, when the pending mask is empty and the context is picked for update.
- WAIT→IDLE on finish, when the finishing step completes.

Only one context is updated per cycle; among those whose mask is empty, the lowest index goes first. The program has four steps:
- START (code 0): calls unit 0 with the packet. It then jumps on the low two bits of that reply: 0 goes to SORT, 1 goes to OUT, and any other value goes to FAULT.
- SORT (code 1): calls unit 0 with `a` and unit 1 with the packet. It stores both replies and goes to OUT.
- OUT (code 2): calls unit 1 with `a+b`. It emits the reply and returns to START.
- FAULT (code 3): calls no unit. It emits all-ones and returns to START.

Top module: `thread_step_engine`

## Requirements
- R1: After reset, `pkt_ready` is 1 and `req_valid`, `step_valid` and `done_valid` are all 0.
- R2: A packet offered while `pkt_ready` is 1 is taken on that edge by the lowest-numbered IDLE context. `pkt_ready` is 0 while no context is IDLE.
- R3: At most one context issues per cycle, and a grant is only given to a READY context. Grants rotate round-robin starting after the last granted context, and no cycle with a READY context goes without a grant.
- R4: In the issue cycle, `step_valid` is 1, `step_tag` is the context and `step_pc` is the step code. `req_valid` bit u is 1 exactly for the units that step calls: START 01, SORT 11, OUT 10, FAULT 00. Each active unit's tag equals `step_tag`.
- R5: A context never issues again while any of its calls is still unanswered. It never has more than one outstanding call per unit. Replies are accepted in any order and with any delay.
- R6: START passes the packet to unit 0. It jumps on the low two bits of that reply: 0 goes to SORT, 1 goes to OUT, and 2 or 3 go to FAULT. The reply is stored in `a`.
- R7: SORT passes `a` to unit 0 and the packet to unit 1, stores the replies in `a` and `b`, then goes to OUT. `b` is 0 on load.
- R8: OUT passes `a+b` (modulo 2^DW) to unit 1. In its update cycle, `done_valid` is 1 and `done_value` holds that reply, along with the context tag and the packet. The context then returns to IDLE.
- R9: FAULT calls no unit. It finishes with `done_value` all-ones.
- R10: Each packet's trace of issued step codes is exactly 0,1,2 or 0,2 or 0,3, chosen by the jump of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | New packet offered |
| pkt_data | input | DW | Packet word |
| pkt_ready | output | 1 | Some context is IDLE |
| req_valid | output | NFU | Call to unit u this cycle |
| req_tag | output | NFU*TW | Context tag per unit |
| req_arg | output | NFU*DW | Call argument per unit |
| rsp_valid | input | NFU | Reply from unit u |
| rsp_tag | input | NFU*TW | Context tag of each reply |
| rsp_data | input | NFU*DW | Reply data per unit |
| step_valid | output | 1 | A step issues this cycle |
| step_tag | output | TW | Issuing context |
| step_pc | output | 2 | Code of the issued step |
| done_valid | output | 1 | A packet finishes this cycle |
| done_tag | output | TW | Finishing context |
| done_pkt | output | DW | Packet word of that context |
| done_value | output | DW | Result of the packet |

## Verification
A corrupted pending mask shows up quickly. If the mask is released early, the step port reports a new issue while the unit model still holds a call for that tag, which is seen on that very cycle. If the mask is never cleared, the context never reaches done and `pkt_ready` eventually stays low. A wrong step pointer or a wrong jump changes the step trace at the next issue of that context. A wrong edit of `a` or `b` only shows in `done_value` at the end of the packet, two or three steps later. A wrong load choice or arbitration shows in the order of `step_tag` values while several contexts are loaded back to back.

// File: rtl/tse_pkg.sv
package tse_pkg;
    localparam int NFU = 2;

    typedef enum logic [1:0] {
        PC_START = 2'd0,
        PC_SORT  = 2'd1,
        PC_OUT   = 2'd2,
        PC_FAULT = 2'd3
    } pc_e;

    typedef enum logic [1:0] {
        CX_IDLE  = 2'd0,
        CX_READY = 2'd1,
        CX_WAIT  = 2'd2
    } cx_e;
endpackage

// File: rtl/tse_rr_arb.sv
module tse_rr_arb #(
    parameter int N  = 4,
    parameter int TW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [TW-1:0] gidx,
    output logic          gany
);
    logic [TW-1:0] last_q;

    always_comb begin
        grant = '0;
        gidx  = '0;
        gany  = 1'b0;
        for (int i = 1; i <= N; i++) begin
            int idx;
            idx = (int'(last_q) + i) % N;
            if (!gany && req[idx]) begin
                gany       = 1'b1;
                grant[idx] = 1'b1;
                gidx       = TW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= TW'(N - 1);
        else if (gany) last_q <= gidx;
    end

    // R3
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));
    // R3
    no_idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> gany);
endmodule

// File: rtl/tse_program.sv
module tse_program
    import tse_pkg::*;
#(
    parameter int DW = 16
) (
    input  pc_e              i_pc,
    input  logic [DW-1:0]    i_pkt,
    input  logic [DW-1:0]    i_a,
    input  logic [DW-1:0]    i_b,
    output logic [NFU-1:0]   i_use,
    output logic [NFU*DW-1:0] i_arg,
    input  pc_e              u_pc,
    input  logic [DW-1:0]    u_a,
    input  logic [DW-1:0]    u_b,
    input  logic [NFU*DW-1:0] u_rsp,
    output logic [DW-1:0]    u_na,
    output logic [DW-1:0]    u_nb,
    output pc_e              u_npc,
    output logic             u_fin,
    output logic [DW-1:0]    u_val
);
    logic [DW-1:0] r0, r1;
    assign r0 = u_rsp[0 +: DW];
    assign r1 = u_rsp[DW +: DW];

    // request builder
    always_comb begin
        i_use = '0;
        i_arg = '0;
        unique case (i_pc)
            PC_START: begin i_use = 2'b01; i_arg[0 +: DW] = i_pkt; end
            PC_SORT:  begin i_use = 2'b11; i_arg[0 +: DW] = i_a; i_arg[DW +: DW] = i_pkt; end
            PC_OUT:   begin i_use = 2'b10; i_arg[DW +: DW] = i_a + i_b; end
            PC_FAULT: i_use = 2'b00;
            default:  i_use = 2'b00;
        endcase
    end

    // context edit and jump
    always_comb begin
        u_na  = u_a;
        u_nb  = u_b;
        u_npc = PC_START;
        u_fin = 1'b0;
        u_val = '0;
        unique case (u_pc)
            PC_START: begin
                u_na = r0;
                case (r0[1:0])
                    2'd0:    u_npc = PC_SORT;
                    2'd1:    u_npc = PC_OUT;
                    default: u_npc = PC_FAULT;
                endcase
            end
            PC_SORT: begin u_na = r0; u_nb = r1; u_npc = PC_OUT; end
            PC_OUT:  begin u_nb = r1; u_fin = 1'b1; u_val = r1; end
            PC_FAULT: begin u_nb = '1; u_fin = 1'b1; u_val = '1; end
            default: u_npc = PC_START;
        endcase
    end
endmodule

// File: rtl/tse_ctx.sv
module tse_ctx
    import tse_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 2,
    parameter int ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DW-1:0]     load_pkt,
    input  logic              issue,
    input  logic [NFU-1:0]    iss_use,
    input  logic [NFU-1:0]    rsp_valid,
    input  logic [NFU*TW-1:0] rsp_tag,
    input  logic [NFU*DW-1:0] rsp_data,
    input  logic              upd,
    input  pc_e               upd_pc,
    input  logic [DW-1:0]     upd_a,
    input  logic [DW-1:0]     upd_b,
    input  logic              upd_fin,
    output cx_e               st,
    output pc_e               pc,
    output logic [DW-1:0]     pkt,
    output logic [DW-1:0]     a,
    output logic [DW-1:0]     b,
    output logic [NFU*DW-1:0] rbuf,
    output logic              release_ok
);
    cx_e            st_n;
    logic [NFU-1:0] pend_q;
    logic [NFU-1:0] hit;

    for (genvar u = 0; u < NFU; u++) begin : g_hit
        assign hit[u] = rsp_valid[u] && (rsp_tag[u*TW +: TW] == TW'(ID));
        // R5
        reply_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[u] |-> pend_q[u]);
    end

    assign release_ok = (st == CX_WAIT) && (pend_q == '0);

    always_comb begin
        st_n = st;
        unique case (st)
            CX_IDLE:  if (load)  st_n = CX_READY;
            CX_READY: if (issue) st_n = CX_WAIT;
            CX_WAIT:  if (upd)   st_n = upd_fin ? CX_IDLE : CX_READY;
            default:  st_n = CX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= CX_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            pc     <= PC_START;
            pkt    <= '0;
            a      <= '0;
            b      <= '0;
            rbuf   <= '0;
        end else begin
            for (int u = 0; u < NFU; u++)
                if (hit[u]) rbuf[u*DW +: DW] <= rsp_data[u*DW +: DW];
            if (issue) pend_q <= iss_use;
            else       pend_q <= pend_q & ~hit;
            if (load) begin
                pkt <= load_pkt;
                a   <= '0;
                b   <= '0;
                pc  <= PC_START;
            end else if (upd) begin
                a  <= upd_a;
                b  <= upd_b;
                pc <= upd_pc;
            end
        end
    end

    // R3
    issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (st == CX_READY));
    // R2
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (st == CX_IDLE));
    // R5
    update_after_barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> (st == CX_WAIT) && (pend_q == '0));
endmodule

// File: rtl/thread_step_engine.sv
module thread_step_engine
    import tse_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NCTX = 4,
    parameter int TW   = $clog2(NCTX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [DW-1:0]     pkt_data,
    output logic              pkt_ready,
    output logic [NFU-1:0]    req_valid,
    output logic [NFU*TW-1:0] req_tag,
    output logic [NFU*DW-1:0] req_arg,
    input  logic [NFU-1:0]    rsp_valid,
    input  logic [NFU*TW-1:0] rsp_tag,
    input  logic [NFU*DW-1:0] rsp_data,
    output logic              step_valid,
    output logic [TW-1:0]     step_tag,
    output logic [1:0]        step_pc,
    output logic              done_valid,
    output logic [TW-1:0]     done_tag,
    output logic [DW-1:0]     done_pkt,
    output logic [DW-1:0]     done_value
);
    cx_e               c_st   [NCTX];
    pc_e               c_pc   [NCTX];
    logic [DW-1:0]     c_pkt  [NCTX];
    logic [DW-1:0]     c_a    [NCTX];
    logic [DW-1:0]     c_b    [NCTX];
    logic [NFU*DW-1:0] c_rbuf [NCTX];
    logic [NCTX-1:0]   c_idle, c_ready, c_rel;
    logic [NCTX-1:0]   load_sel, upd_sel, grant;
    logic [TW-1:0]     gidx, uidx;
    logic              gany, uany, lany;

    logic [NFU-1:0]    i_use;
    logic [NFU*DW-1:0] i_arg;
    logic [DW-1:0]     u_na, u_nb, u_val;
    pc_e               u_npc;
    logic              u_fin;

    // lowest idle takes the packet, lowest released context updates
    always_comb begin
        load_sel = '0; upd_sel = '0; uidx = '0;
        lany = 1'b0; uany = 1'b0;
        for (int i = 0; i < NCTX; i++) begin
            if (!lany && c_idle[i]) begin lany = 1'b1; load_sel[i] = 1'b1; end
            if (!uany && c_rel[i])  begin uany = 1'b1; upd_sel[i] = 1'b1; uidx = TW'(i); end
        end
    end

    tse_rr_arb #(.N(NCTX), .TW(TW)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(c_ready),
        .grant(grant), .gidx(gidx), .gany(gany)
    );

    tse_program #(.DW(DW)) u_prog (
        .i_pc(c_pc[gidx]), .i_pkt(c_pkt[gidx]), .i_a(c_a[gidx]), .i_b(c_b[gidx]),
        .i_use(i_use), .i_arg(i_arg),
        .u_pc(c_pc[uidx]), .u_a(c_a[uidx]), .u_b(c_b[uidx]), .u_rsp(c_rbuf[uidx]),
        .u_na(u_na), .u_nb(u_nb), .u_npc(u_npc), .u_fin(u_fin), .u_val(u_val)
    );

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        tse_ctx #(.DW(DW), .TW(TW), .ID(c)) u_ctx (
            .clk(clk), .rst_n(rst_n),
            .load(load_sel[c] && pkt_valid), .load_pkt(pkt_data),
            .issue(grant[c]), .iss_use(i_use),
            .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
            .upd(upd_sel[c]), .upd_pc(u_npc), .upd_a(u_na), .upd_b(u_nb), .upd_fin(u_fin),
            .st(c_st[c]), .pc(c_pc[c]), .pkt(c_pkt[c]), .a(c_a[c]), .b(c_b[c]),
            .rbuf(c_rbuf[c]), .release_ok(c_rel[c])
        );
        assign c_idle[c]  = (c_st[c] == CX_IDLE);
        assign c_ready[c] = (c_st[c] == CX_READY);
    end

    always_comb begin
        pkt_ready  = lany;
        step_valid = gany;
        step_tag   = gidx;
        step_pc    = c_pc[gidx];
        req_valid  = gany ? i_use : '0;
        req_arg    = i_arg;
        for (int u = 0; u < NFU; u++) req_tag[u*TW +: TW] = gidx;
        done_valid = uany && u_fin;
        done_tag   = uidx;
        done_pkt   = c_pkt[uidx];
        done_value = u_val;
    end

    // R9
    fault_no_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_pc == 2'd3) |-> (req_valid == '0));
    // R2
    full_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_idle == '0) |-> !pkt_ready);
endmodule

// File: tb/thread_step_engine_tb.sv
module thread_step_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int NCTX = 4;
    localparam int TW = 2;
    localparam int NFU = 2;
    localparam int NVEC = 8;
    // {route, packet}: route 0 = START,SORT,OUT  1 = START,OUT  2 = START,FAULT
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd0, 16'h1233}, {2'd1, 16'h4560}, {2'd2, 16'h0001}, {2'd0, 16'hABCF},
        {2'd2, 16'h7772}, {2'd1, 16'h0FF0}, {2'd0, 16'hFFFF}, {2'd1, 16'h8004}
    };
    localparam logic [17:0] DIR [4] = '{
        {2'd0, 16'h0003}, {2'd1, 16'h0010}, {2'd2, 16'h0022}, {2'd0, 16'h5557}
    };

    logic clk = 0, rst_n = 0;
    logic pkt_valid = 0;
    logic [DW-1:0] pkt_data = '0;
    logic pkt_ready;
    logic [NFU-1:0] req_valid;
    logic [NFU*TW-1:0] req_tag;
    logic [NFU*DW-1:0] req_arg;
    logic [NFU-1:0] rsp_valid;
    logic [NFU*TW-1:0] rsp_tag;
    logic [NFU*DW-1:0] rsp_data;
    logic step_valid;
    logic [TW-1:0] step_tag;
    logic [1:0] step_pc;
    logic done_valid;
    logic [TW-1:0] done_tag;
    logic [DW-1:0] done_pkt, done_value;

    thread_step_engine #(.DW(DW), .NCTX(NCTX)) u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_ready(pkt_ready), .req_valid(req_valid), .req_tag(req_tag), .req_arg(req_arg),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .step_valid(step_valid), .step_tag(step_tag), .step_pc(step_pc),
        .done_valid(done_valid), .done_tag(done_tag), .done_pkt(done_pkt), .done_value(done_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, done_cnt = 0, cyc = 0, sqn = 0;
    logic stall = 0;
    logic [TW-1:0] sq [8];
    logic [5:0] tr [NCTX];
    int tlen [NCTX];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fu0(input logic [DW-1:0] x); return x + 16'h0101; endfunction
    function automatic logic [DW-1:0] fu1(input logic [DW-1:0] x); return x ^ 16'h00F0; endfunction

    function automatic logic [DW-1:0] exp_val(input logic [DW-1:0] p);
        logic [DW-1:0] a0;
        a0 = fu0(p);
        if (a0[1:0] == 2'd0) return fu1(fu0(a0) + fu1(p));
        if (a0[1:0] == 2'd1) return fu1(a0);
        return '1;
    endfunction

    // behavioural unit models, one outstanding call per tag per unit
    logic          busy [NFU][NCTX];
    int            cnt  [NFU][NCTX];
    logic [DW-1:0] dat  [NFU][NCTX];
    logic [NFU-1:0]    rv_q;
    logic [NFU*TW-1:0] rt_q;
    logic [NFU*DW-1:0] rd_q;
    assign rsp_valid = rv_q;
    assign rsp_tag   = rt_q;
    assign rsp_data  = rd_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            rv_q <= '0; rt_q <= '0; rd_q <= '0;
            for (int u = 0; u < NFU; u++)
                for (int t = 0; t < NCTX; t++) begin busy[u][t] = 0; cnt[u][t] = 0; dat[u][t] = '0; end
        end else begin
            for (int u = 0; u < NFU; u++) begin
                bit sent;
                sent = 0;
                rv_q[u] <= 1'b0;
                for (int t = 0; t < NCTX; t++)
                    if (!sent && !stall && busy[u][t] && cnt[u][t] == 0) begin
                        sent = 1;
                        rv_q[u] <= 1'b1;
                        rt_q[u*TW +: TW] <= TW'(t);
                        rd_q[u*DW +: DW] <= dat[u][t];
                        busy[u][t] = 0;
                    end
                for (int t = 0; t < NCTX; t++)
                    if (busy[u][t] && cnt[u][t] != 0) cnt[u][t]--;
                if (req_valid[u]) begin
                    int t;
                    t = int'(req_tag[u*TW +: TW]);
                    // R5: no second call to a unit while one is pending
                    chk(!busy[u][t], "R5 double call", 32'(t), 32'hFFFF);
                    busy[u][t] = 1;
                    cnt[u][t]  = int'($urandom % 6);
                    dat[u][t]  = (u == 0) ? fu0(req_arg[u*DW +: DW]) : fu1(req_arg[u*DW +: DW]);
                end
            end
        end
    end

    // port observers
    always @(negedge clk) begin
        if (rst_n && step_valid) begin
            logic [1:0] ep;
            ep = (step_pc == 2'd0) ? 2'b01 : (step_pc == 2'd1) ? 2'b11 :
                 (step_pc == 2'd2) ? 2'b10 : 2'b00;
            // R5 barrier: every earlier call of this context answered
            chk(!busy[0][step_tag] && !busy[1][step_tag], "R5 issue before barrier", 32'(step_tag), 32'hFFFF);
            // R4 unit pattern and tags
            chk(req_valid == ep, "R4 req_valid", 32'(req_valid), 32'(ep));
            for (int u = 0; u < NFU; u++)
                if (req_valid[u]) chk(req_tag[u*TW +: TW] == step_tag, "R4 req_tag",
                                      32'(req_tag[u*TW +: TW]), 32'(step_tag));
            tr[step_tag]   = {tr[step_tag][3:0], step_pc};
            tlen[step_tag] = tlen[step_tag] + 1;
            if (sqn < 8) begin sq[sqn] = step_tag; sqn++; end
        end
        if (rst_n && done_valid) begin
            int idx;
            logic [1:0] route;
            idx = -1; route = 2'd0;
            for (int i = 0; i < NVEC; i++) if (VEC[i][15:0] == done_pkt) begin idx = i; route = VEC[i][17:16]; end
            for (int i = 0; i < 4; i++)    if (DIR[i][15:0] == done_pkt) begin idx = i; route = DIR[i][17:16]; end
            chk(idx >= 0, "R8 unknown done_pkt", 32'(done_pkt), 32'hFFFF);
            // R6 R7 R8 R9 result value
            chk(done_value == exp_val(done_pkt), "R8 done_value", 32'(done_value), 32'(exp_val(done_pkt)));
            // R10 trace
            if (route == 2'd0)
                chk(tlen[done_tag] == 3 && tr[done_tag] == 6'b00_01_10, "R10 trace SORT route",
                    {26'd0, tr[done_tag]}, 32'h06);
            else if (route == 2'd1)
                chk(tlen[done_tag] == 2 && tr[done_tag][3:0] == 4'b00_10, "R10 trace OUT route",
                    {26'd0, tr[done_tag]}, 32'h02);
            else
                chk(tlen[done_tag] == 2 && tr[done_tag][3:0] == 4'b00_11, "R9 R10 trace FAULT route",
                    {26'd0, tr[done_tag]}, 32'h03);
            tr[done_tag] = '0; tlen[done_tag] = 0;
            done_cnt++;
        end
    end

    task automatic offer(input logic [DW-1:0] p);
        while (!pkt_ready) @(negedge clk);
        pkt_valid = 1; pkt_data = p;
        @(negedge clk);
        pkt_valid = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++; errors++;
            $display("FAIL watchdog expired done=%0d", done_cnt);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NCTX; t++) begin tr[t] = '0; tlen[t] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pkt_ready == 1'b1, "R1 pkt_ready", 32'(pkt_ready), 32'h1);
        chk(req_valid == '0 && step_valid == 1'b0, "R1 idle issue", 32'(req_valid), 32'h0);
        chk(done_valid == 1'b0, "R1 done_valid", 32'(done_valid), 32'h0);
        rst_n = 1;
        @(negedge clk);

        // table walk, random latencies, interleaved threads
        for (int i = 0; i < NVEC; i++) offer(VEC[i][15:0]);
        while (done_cnt < NVEC) @(negedge clk);
        repeat (3) @(negedge clk);

        // directed: replies held, four packets back to back (R2 R3)
        stall = 1; sqn = 0;
        for (int i = 0; i < 4; i++) begin
            chk(pkt_ready == 1'b1, "R2 ready while a context idle", 32'(pkt_ready), 32'h1);
            pkt_valid = 1; pkt_data = DIR[i][15:0];
            @(negedge clk);
        end
        pkt_valid = 0;
        repeat (2) @(negedge clk);
        chk(pkt_ready == 1'b0, "R2 ready with all contexts busy", 32'(pkt_ready), 32'h0);
        chk(sqn == 4, "R3 one issue per loaded context", 32'(sqn), 32'd4);
        for (int i = 0; i < 4; i++)
            chk(sq[i] == TW'(i), "R2 lowest idle context loaded", 32'(sq[i]), 32'(i));
        chk(done_valid == 1'b0, "R5 no finish while replies held", 32'(done_valid), 32'h0);
        stall = 0;
        while (done_cnt < NVEC + 4) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(pkt_ready == 1'b1, "R8 contexts freed after finish", 32'(pkt_ready), 32'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule